// File: doc/BRIEF.md
# Spectrogram Frame Builder

This block takes the output of a short-time Fourier magnitude stage and turns it into the input frame of a speech classifier. Magnitudes arrive as IEEE single-precision words, one per beat, on an AXI4-Stream style input (data, valid, last; the block accepts every beat). Each packet carries 256 magnitudes. Only the lower 129 bins carry information, because the spectrum of a real signal is mirrored. Those 129 bins are converted to signed 16-bit fixed point with 8 fractional bits (Q8.8) and collected into a row buffer. The remaining bins are dropped.

A complete, correctly framed packet commits its row into a circular store of 124 time rows, which is one second of audio at one row per 8 ms. The first trigger comes once 124 rows have been committed. After that, a trigger comes after every further 31 rows, which is a quarter frame or about 250 ms. The classifier therefore sees four overlapping one-second windows. With each trigger the block latches the slot of the oldest row as the frame base. A read port returns any (time row, bin) of the current frame, with time row 0 being the oldest, so the consumer never deals with the circular layout.

The packet state machine has three states. PK_KEEP stores bins 0..128. Its transition to PK_DROP happens at bin 128. PK_DROP discards bins 129..255. Its transition back to PK_KEEP happens on the last beat, and it commits the row when that beat is index 255. Its transition to PK_RESYNC happens when index 255 passes without a last flag. PK_RESYNC ignores beats until the next last flag and then returns to PK_KEEP. The frame state machine has two states. FR_FILL counts the first 124 commits. Its transition to FR_LIVE fires the first trigger. In FR_LIVE a trigger fires every 31 commits.

Top module: `spec_frame_builder`

## Requirements
- R1: Of each 256-beat packet, beats with index 0..128 become bins 0..128 of the row, and beats 129..255 have no effect on stored data.
- R2: Each kept word is converted to two's-complement Q8.8 by truncation toward zero. Values of +128.0 or more give 0x7FFF, and values of -128.0 or less give 0x8000 (for example -1.0 gives 0xFF00, and 2^-8 gives 0x0001).
- R3: A NaN (exponent 255, fraction nonzero) gives 0x0000. A zero or denormal (exponent 0) gives 0x0000. An infinity saturates by its sign.
- R4: No trigger occurs until 124 rows have been committed. The first trigger is a one-cycle pulse in the cycle after the final beat of the 124th row, and it carries frame base 0.
- R5: After the first trigger, a trigger pulses in the cycle after every 31st further committed row. Its frame base is the slot of the oldest stored row, so the successive bases are 31, 62, 93, 0 and so on.
- R6: A read with rd_en set returns data on rd_data with rd_valid high one cycle later. Time row r maps to slot (base + r) mod 124, so row 0 is the oldest row of the latched frame.
- R7: A last flag on any beat other than index 255 sets the sticky framing_err flag. The partial row is not stored and does not count toward a trigger.
- R8: A packet that reaches index 255 without a last flag sets framing_err, and the block ignores beats until the next last flag. The packet after that starts at bin 0.
- R9: After reset, frame_trig, framing_err and rd_valid are low.
- R10: A read of a bin index of 129 or more returns 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_tdata | input | 32 | Single-precision magnitude |
| s_tvalid | input | 1 | Beat present |
| s_tlast | input | 1 | Final beat of a packet |
| frame_trig | output | 1 | One-cycle inference trigger |
| frame_base | output | 7 | Slot of the oldest row of the latched frame |
| framing_err | output | 1 | Sticky framing error |
| rd_en | input | 1 | Read request |
| rd_row | input | 7 | Time row, 0 = oldest (0..123) |
| rd_bin | input | 8 | Frequency bin (0..128) |
| rd_data | output | 16 | Q8.8 value read |
| rd_valid | output | 1 | rd_data valid |

## Verification
The assertions assume two things about the inputs: rd_row stays below 124, and the upstream source only sends beats, with no backpressure. The bench keeps to both. It draws read rows from 0..123 and drives valid beats with random idle gaps. It injects malformed packets only between complete rows, so each assertion on trigger spacing and base alignment sees whole committed rows.

// File: rtl/spec_pkg.sv
package spec_pkg;
    localparam int unsigned QW = 16;

    typedef enum logic [1:0] {
        PK_KEEP,
        PK_DROP,
        PK_RESYNC
    } pkt_state_e;

    typedef enum logic {
        FR_FILL,
        FR_LIVE
    } frame_state_e;
endpackage

// File: rtl/f32_to_q88.sv
module f32_to_q88
    import spec_pkg::*;
#(
    parameter int unsigned FRAC = 8
) (
    input  logic [31:0]   f_i,
    output logic [QW-1:0] q_o
);
    localparam int unsigned EXP_SAT = 150 - FRAC;
    localparam logic [23:0] POS_MAX = 24'((2 ** (QW - 1)) - 1);
    localparam logic [23:0] NEG_MAX = 24'(2 ** (QW - 1));

    logic        sgn;
    logic [7:0]  ex;
    logic [22:0] fr;
    logic [23:0] mag;
    logic [7:0]  sh;
    logic        sat;
    logic        zero;

    always_comb begin
        sgn  = f_i[31];
        ex   = f_i[30:23];
        fr   = f_i[22:0];
        mag  = '0;
        sh   = '0;
        sat  = 1'b0;
        zero = 1'b0;
        if (ex == 8'hFF) begin
            if (fr != '0) zero = 1'b1;
            else          sat  = 1'b1;
        end else if (ex == 8'h00) begin
            zero = 1'b1;
        end else if (ex >= 8'(EXP_SAT)) begin
            sat = 1'b1;
        end else begin
            sh  = 8'(EXP_SAT) - ex;
            mag = {1'b1, fr} >> sh;
            if (!sgn && mag > POS_MAX) sat = 1'b1;
            if (sgn && mag > NEG_MAX)  sat = 1'b1;
        end

        if (zero)     q_o = '0;
        else if (sat) q_o = sgn ? {1'b1, {(QW-1){1'b0}}} : {1'b0, {(QW-1){1'b1}}};
        else          q_o = sgn ? QW'(-mag) : mag[QW-1:0];
    end

    // R2
    always_comb begin
        if (!sgn) pos_never_negative_chk: assert (q_o[QW-1] == 1'b0);
    end
endmodule

// File: rtl/spec_row_assembler.sv
module spec_row_assembler
    import spec_pkg::*;
#(
    parameter int unsigned PKT_LEN   = 256,
    parameter int unsigned KEEP_BINS = 129,
    parameter int unsigned FRAC      = 8,
    localparam int unsigned IDX_W    = $clog2(PKT_LEN),
    localparam int unsigned ROW_BITS = KEEP_BINS * QW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [31:0]         s_tdata,
    input  logic                s_tvalid,
    input  logic                s_tlast,
    output logic                row_commit_o,
    output logic [ROW_BITS-1:0] row_data_o,
    output logic                frame_err_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PKT_LEN - 1);
    localparam logic [IDX_W-1:0] KEEP_END = IDX_W'(KEEP_BINS - 1);

    pkt_state_e       st_q, st_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             set_err;
    logic             store_en;
    logic [QW-1:0]    q_val;
    logic [QW-1:0]    row_buf [KEEP_BINS];

    f32_to_q88 #(.FRAC(FRAC)) u_conv (
        .f_i (s_tdata),
        .q_o (q_val)
    );

    always_comb begin
        st_d         = st_q;
        idx_d        = idx_q;
        set_err      = 1'b0;
        row_commit_o = 1'b0;
        store_en     = 1'b0;
        unique case (st_q)
            PK_KEEP: begin
                if (s_tvalid) begin
                    store_en = 1'b1;
                    if (s_tlast) begin
                        set_err = 1'b1;
                        idx_d   = '0;
                    end else begin
                        idx_d = idx_q + 1'b1;
                        if (idx_q == KEEP_END) st_d = PK_DROP;
                    end
                end
            end
            PK_DROP: begin
                if (s_tvalid) begin
                    if (s_tlast) begin
                        if (idx_q == LAST_IDX) row_commit_o = 1'b1;
                        else                   set_err      = 1'b1;
                        idx_d = '0;
                        st_d  = PK_KEEP;
                    end else if (idx_q == LAST_IDX) begin
                        set_err = 1'b1;
                        st_d    = PK_RESYNC;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
            end
            PK_RESYNC: begin
                if (s_tvalid && s_tlast) begin
                    idx_d = '0;
                    st_d  = PK_KEEP;
                end
            end
            default: st_d = PK_KEEP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= PK_KEEP;
            idx_q <= '0;
        end else begin
            st_q  <= st_d;
            idx_q <= idx_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       frame_err_o <= 1'b0;
        else if (set_err) frame_err_o <= 1'b1;
    end

    for (genvar b = 0; b < KEEP_BINS; b++) begin : g_bin
        always_ff @(posedge clk) begin
            if (store_en && idx_q == IDX_W'(b)) row_buf[b] <= q_val;
        end
        assign row_data_o[b*QW +: QW] = row_buf[b];
    end

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err_o |=> frame_err_o);

    // R8
    resync_flags_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PK_RESYNC) |-> frame_err_o);

    // R1
    keep_index_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PK_KEEP) |-> (idx_q <= KEEP_END));
endmodule

// File: rtl/spec_frame_ctrl.sv
module spec_frame_ctrl
    import spec_pkg::*;
#(
    parameter int unsigned ROWS      = 124,
    parameter int unsigned TRIG_ROWS = 31,
    localparam int unsigned ROW_W    = $clog2(ROWS),
    localparam int unsigned CNT_W    = $clog2(ROWS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit_i,
    output logic [ROW_W-1:0] wr_row_o,
    output logic             trig_o,
    output logic [ROW_W-1:0] base_o
);
    frame_state_e     state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             fire;
    logic [ROW_W-1:0] slot_next;

    assign slot_next = (wr_row_o == ROW_W'(ROWS - 1)) ? '0 : wr_row_o + 1'b1;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        fire    = 1'b0;
        unique case (state_q)
            FR_FILL: begin
                if (commit_i) begin
                    if (cnt_q == CNT_W'(ROWS - 1)) begin
                        state_d = FR_LIVE;
                        cnt_d   = '0;
                        fire    = 1'b1;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            FR_LIVE: begin
                if (commit_i) begin
                    if (cnt_q == CNT_W'(TRIG_ROWS - 1)) begin
                        cnt_d = '0;
                        fire  = 1'b1;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: state_d = FR_FILL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FR_FILL;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_o   <= 1'b0;
            base_o   <= '0;
            wr_row_o <= '0;
        end else begin
            trig_o <= fire;
            if (fire)     base_o   <= slot_next;
            if (commit_i) wr_row_o <= slot_next;
        end
    end

    // R4
    trig_after_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> $past(commit_i));

    // R5
    base_is_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> (base_o == wr_row_o));

    // R5
    base_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        base_o < ROW_W'(ROWS));
endmodule

// File: rtl/spec_frame_store.sv
module spec_frame_store
    import spec_pkg::*;
#(
    parameter int unsigned ROWS      = 124,
    parameter int unsigned KEEP_BINS = 129,
    localparam int unsigned ROW_W    = $clog2(ROWS),
    localparam int unsigned BIN_W    = $clog2(KEEP_BINS),
    localparam int unsigned ROW_BITS = KEEP_BINS * QW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en_i,
    input  logic [ROW_W-1:0]    wr_row_i,
    input  logic [ROW_BITS-1:0] wr_data_i,
    input  logic [ROW_W-1:0]    base_i,
    input  logic                rd_en_i,
    input  logic [ROW_W-1:0]    rd_row_i,
    input  logic [BIN_W-1:0]    rd_bin_i,
    output logic [QW-1:0]       rd_data_o,
    output logic                rd_valid_o
);
    logic [ROW_BITS-1:0] mem [ROWS];
    logic [ROW_W:0]      sum;
    logic [ROW_W-1:0]    phys;
    logic [ROW_BITS-1:0] word;

    always_comb begin
        sum  = {1'b0, rd_row_i} + {1'b0, base_i};
        phys = (sum >= (ROW_W+1)'(ROWS)) ? ROW_W'(sum - (ROW_W+1)'(ROWS)) : sum[ROW_W-1:0];
        word = mem[phys];
    end

    always_ff @(posedge clk) begin
        if (wr_en_i) mem[wr_row_i] <= wr_data_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_o <= 1'b0;
            rd_data_o  <= '0;
        end else begin
            rd_valid_o <= rd_en_i;
            if (rd_en_i) begin
                if (rd_bin_i < BIN_W'(KEEP_BINS)) rd_data_o <= word[rd_bin_i*QW +: QW];
                else                               rd_data_o <= '0;
            end
        end
    end

    // R6
    read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_i |=> rd_valid_o);

    // R6
    read_row_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_i |-> (rd_row_i < ROW_W'(ROWS)));
endmodule

// File: rtl/spec_frame_builder.sv
module spec_frame_builder
    import spec_pkg::*;
#(
    parameter int unsigned PKT_LEN   = 256,
    parameter int unsigned KEEP_BINS = 129,
    parameter int unsigned ROWS      = 124,
    parameter int unsigned TRIG_ROWS = 31,
    parameter int unsigned FRAC      = 8,
    localparam int unsigned ROW_W    = $clog2(ROWS),
    localparam int unsigned BIN_W    = $clog2(KEEP_BINS),
    localparam int unsigned ROW_BITS = KEEP_BINS * QW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [31:0]      s_tdata,
    input  logic             s_tvalid,
    input  logic             s_tlast,
    output logic             frame_trig,
    output logic [ROW_W-1:0] frame_base,
    output logic             framing_err,
    input  logic             rd_en,
    input  logic [ROW_W-1:0] rd_row,
    input  logic [BIN_W-1:0] rd_bin,
    output logic [QW-1:0]    rd_data,
    output logic             rd_valid
);
    logic                commit;
    logic [ROW_BITS-1:0] row_data;
    logic [ROW_W-1:0]    wr_row;

    spec_row_assembler #(
        .PKT_LEN   (PKT_LEN),
        .KEEP_BINS (KEEP_BINS),
        .FRAC      (FRAC)
    ) u_asm (
        .clk          (clk),
        .rst_n        (rst_n),
        .s_tdata      (s_tdata),
        .s_tvalid     (s_tvalid),
        .s_tlast      (s_tlast),
        .row_commit_o (commit),
        .row_data_o   (row_data),
        .frame_err_o  (framing_err)
    );

    spec_frame_ctrl #(
        .ROWS      (ROWS),
        .TRIG_ROWS (TRIG_ROWS)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (commit),
        .wr_row_o (wr_row),
        .trig_o   (frame_trig),
        .base_o   (frame_base)
    );

    spec_frame_store #(
        .ROWS      (ROWS),
        .KEEP_BINS (KEEP_BINS)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (commit),
        .wr_row_i   (wr_row),
        .wr_data_i  (row_data),
        .base_i     (frame_base),
        .rd_en_i    (rd_en),
        .rd_row_i   (rd_row),
        .rd_bin_i   (rd_bin),
        .rd_data_o  (rd_data),
        .rd_valid_o (rd_valid)
    );
endmodule

// File: tb/spec_frame_builder_bench.sv
module spec_frame_builder_bench;
    localparam int NROWS = 124;
    localparam int NKEEP = 129;
    localparam int NPKT  = 256;
    localparam int NTRIG = 31;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] s_tdata = '0;
    logic        s_tvalid = 1'b0;
    logic        s_tlast = 1'b0;
    logic        frame_trig;
    logic [6:0]  frame_base;
    logic        framing_err;
    logic        rd_en = 1'b0;
    logic [6:0]  rd_row = '0;
    logic [7:0]  rd_bin = '0;
    logic [15:0] rd_data;
    logic        rd_valid;

    int checks = 0;
    int errors = 0;
    int committed = 0;

    always #2 clk = ~clk;

    spec_frame_builder u_spec_frame_builder (
        .clk(clk), .rst_n(rst_n), .s_tdata(s_tdata), .s_tvalid(s_tvalid),
        .s_tlast(s_tlast), .frame_trig(frame_trig), .frame_base(frame_base),
        .framing_err(framing_err), .rd_en(rd_en), .rd_row(rd_row),
        .rd_bin(rd_bin), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] gen(input int seq, input int bin);
        int unsigned h;
        logic [7:0]  ex;
        logic        sg;
        if (seq == 0) begin
            case (bin)
                0: return 32'h4300_0000;
                1: return 32'hC300_0000;
                2: return 32'h42FF_FFFF;
                3: return 32'hBF80_0000;
                4: return 32'h3B80_0000;
                5: return 32'h3B7F_FFFF;
                6: return 32'hBB7F_FFFF;
                7: return 32'h7FC0_0001;
                8: return 32'hFF80_0000;
                default: ;
            endcase
        end
        h = (int'(seq) * 32'd2654435761) ^ (int'(bin) * 32'd40503) ^ 32'h5bd1_e995;
        h = h ^ (h >> 15);
        h = h * 32'd2246822519;
        h = h ^ (h >> 13);
        case (h % 16)
            0: return {h[31], 8'hFF, 1'b1, h[21:0]};
            1: return {h[31], 8'h00, h[22:0]};
            2: return {h[31], 8'hFF, 23'd0};
            3: return 32'd0;
            default: begin
                ex = 8'(110 + ((h >> 4) % 40));
                sg = ((h >> 12) % 8) == 0;
                return {sg, ex, h[27:5]};
            end
        endcase
    endfunction

    function automatic logic [15:0] ref_q(input logic [31:0] f);
        real v;
        int  e;
        e = int'(f[30:23]);
        if (e == 255 && f[22:0] != 0) return 16'h0000;
        if (e == 0) return 16'h0000;
        if (e == 255) return f[31] ? 16'h8000 : 16'h7FFF;
        v = (1.0 + real'(f[22:0]) / 8388608.0) * (2.0 ** real'(e - 127)) * 256.0;
        if (f[31]) v = -v;
        if (v >= 32768.0) return 16'h7FFF;
        if (v <= -32768.0) return 16'h8000;
        return 16'($rtoi(v));
    endfunction

    task automatic beat(input logic [31:0] d, input logic l);
        while ($urandom_range(0, 4) == 0) begin
            s_tvalid = 1'b0;
            @(negedge clk);
        end
        s_tvalid = 1'b1;
        s_tdata  = d;
        s_tlast  = l;
        @(negedge clk);
        s_tvalid = 1'b0;
        s_tlast  = 1'b0;
    endtask

    task automatic send_row();
        bit exp_trig;
        for (int i = 0; i < NPKT; i++)
            beat((i < NKEEP) ? gen(committed, i) : $urandom, i == NPKT - 1);
        committed++;
        exp_trig = (committed >= NROWS) && (((committed - NROWS) % NTRIG) == 0);
        chk(frame_trig == exp_trig, (committed <= NROWS) ? "R4" : "R5",
            "trigger after row", int'(frame_trig), int'(exp_trig));
        if (exp_trig)
            chk(int'(frame_base) == ((committed - NROWS) % NROWS),
                (committed == NROWS) ? "R4" : "R5", "frame base",
                int'(frame_base), (committed - NROWS) % NROWS);
    endtask

    task automatic rd(input int row, input int bin, output logic [15:0] d, output logic v);
        rd_en  = 1'b1;
        rd_row = 7'(row);
        rd_bin = 8'(bin);
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
        v = rd_valid;
    endtask

    task automatic check_cell(input int row, input int bin);
        logic [15:0] d, e;
        logic        v;
        rd(row, bin, d, v);
        e = ref_q(gen(committed - NROWS + row, bin));
        chk(v == 1'b1, "R6", "read valid", int'(v), 1);
        chk(d == e, (committed == NROWS && row == 0 && bin < 9) ? "R2_R3" : "R6_R1",
            $sformatf("row %0d bin %0d", row, bin), int'(d), int'(e));
    endtask

    task automatic check_frame();
        for (int b = 0; b < NKEEP; b++) begin
            check_cell(0, b);
            check_cell(NROWS - 1, b);
        end
        for (int k = 0; k < 150; k++)
            check_cell($urandom_range(0, NROWS - 1), $urandom_range(0, NKEEP - 1));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL R4 watchdog: actual=timeout expected=completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] d;
        logic        v;
        void'($urandom(32'd20240607));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk(frame_trig == 1'b0, "R9", "trig after reset", int'(frame_trig), 0);
        chk(framing_err == 1'b0, "R9", "err after reset", int'(framing_err), 0);
        chk(rd_valid == 1'b0, "R9", "rd_valid after reset", int'(rd_valid), 0);

        // R4: first frame, directed conversion corners in row 0 (R2, R3)
        for (int r = 0; r < NROWS; r++) send_row();
        chk(framing_err == 1'b0, "R7", "no error on clean stream", int'(framing_err), 0);
        @(negedge clk);
        chk(frame_trig == 1'b0, "R4", "trigger is one cycle", int'(frame_trig), 0);
        check_frame();
        // R10 out-of-range bin
        for (int b = NKEEP; b < NKEEP + 8; b++) begin
            rd(5, b, d, v);
            chk(d == 16'h0000, "R10", "bin beyond range", int'(d), 0);
        end

        // R5 second trigger, base 31
        for (int r = 0; r < NTRIG; r++) send_row();
        check_frame();

        // R7 short packet (last inside kept bins)
        for (int i = 0; i < 100; i++) beat(32'h4780_0000, i == 99);
        chk(framing_err == 1'b1, "R7", "short packet sets error", int'(framing_err), 1);
        chk(frame_trig == 1'b0, "R7", "short packet no trigger", int'(frame_trig), 0);
        // R7 last inside dropped bins
        for (int i = 0; i < 200; i++) beat(32'h4780_0000, i == 199);
        // R8 overlong packet, resync on next last
        for (int i = 0; i < NPKT + 20; i++) beat(32'h4780_0000, i == NPKT + 19);
        chk(framing_err == 1'b1, "R8", "error stays set", int'(framing_err), 1);

        // R7/R8: bad packets did not count; third trigger base 62
        for (int r = 0; r < NTRIG; r++) send_row();
        check_frame();
        chk(framing_err == 1'b1, "R7", "error sticky", int'(framing_err), 1);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule